// File: doc/BRIEF.md
# Caption Line Slice Selector

This block decides, line by line, which horizontal lines of a video field are handed to a closed-caption data slicer. It watches separated horizontal and vertical sync, counts horizontal sync pulses from the start of each field, and issues a one-clock slice strobe on the lines that carry caption data. Two lines per field are sliced, and this happens in both fields. One is a fixed caption line set by a parameter. The other is chosen at run time through a 5-bit line setting.

A 2-bit selector and a field-select bit choose which of the two sliced lines also gets a reference strobe. The analog side uses that strobe to build its slice threshold from the clock run-in. A field flag tells the first field from the second. The flag is set by where the vertical sync falling edge lands within the horizontal line period. Both sync inputs are asynchronous and are synchronised inside the block. The configuration inputs are plain levels and are expected to change only between lines.

Top module: `cc_line_picker`

## Requirements
- R1: A falling edge of `vsync_in` clears the line count to 0. Each later rising edge of `hsync_in` adds one, so the first horizontal sync of a field is count 1.
- R2: `slice_stb` is a single-clock pulse. If `hsync_in` rises before clock edge k, the pulse is high between edges k+2 and k+3.
- R3: A strobe is issued on the line whose count equals `cfg_line` (1 to 31). A setting of 0 never produces a programmable strobe.
- R4: The line whose count equals the parameter FIXED_CNT (default 21) is always sliced, in both fields. If `cfg_line` equals FIXED_CNT, that line gives exactly one strobe.
- R5: The line count saturates at 2^LINE_W-1 (63 by default) and does not wrap. Lines past saturation in a long field are never sliced.
- R6: `cfg_ref_sel` picks the reference line. 2'b00 selects the fixed line and 2'b01 selects the programmable line. 2'b10 and 2'b11 are reserved and produce no `ref_stb`. `ref_stb` only pulses together with `slice_stb`.
- R7: `ref_stb` is issued only when `field_flag` equals `cfg_ref_field` (0 = first field, 1 = second field).
- R8: On each falling edge of `vsync_in`, `field_flag` is loaded with 1 if the time since the last horizontal sync rise is more than half of the last measured line period, and with 0 otherwise. At all other times it holds its value.
- R9: After reset, `slice_stb`, `ref_stb` and `field_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Separated horizontal sync, active high, asynchronous |
| vsync_in | input | 1 | Separated vertical sync, field start on falling edge, asynchronous |
| cfg_line | input | 5 | Programmable caption line count |
| cfg_ref_sel | input | 2 | Reference line select: 00 fixed, 01 programmable, others none |
| cfg_ref_field | input | 1 | Field in which the reference strobe is allowed |
| slice_stb | output | 1 | One-clock pulse marking a line to slice |
| ref_stb | output | 1 | One-clock pulse marking the reference-generation line |
| field_flag | output | 1 | 0 for first field, 1 for second field |

## Verification
The hardest condition to reach is a field long enough to push the line counter into saturation. A wrapping counter would only show its fault on a second pass through the caption lines. The stimulus runs a 100-line field with the programmable line next to the fixed line, so a wrap at 64 would give extra strobes near lines 85 and 86. The field flag is also hard to reach, because it depends on the sub-line phase of the vertical sync edge. The driver drops vertical sync either early or late within a horizontal line of known period, which produces both flag values.

// File: rtl/cc_pick_pkg.sv
package cc_pick_pkg;
  typedef enum logic [1:0] {
    REF_FIXED = 2'b00,
    REF_PROG  = 2'b01,
    REF_RSV2  = 2'b10,
    REF_RSV3  = 2'b11
  } ref_sel_e;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[DEPTH-2:0], async_in};
  end

  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cc_line_counter.sv
module cc_line_counter #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [LINE_W-1:0] cnt,
  output logic [LINE_W-1:0] cnt_nxt
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  always_comb begin
    if (cnt == CNT_MAX) cnt_nxt = CNT_MAX;
    else                cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/cc_field_detect.sv
module cc_field_detect #(
  parameter int PH_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise,
  input  logic vs_fall,
  output logic field_flag
);
  localparam logic [PH_W-1:0] PH_MAX = '1;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      period <= '0;
    end else if (hs_rise) begin
      phase  <= '0;
      period <= phase;
    end else if (phase != PH_MAX) begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       field_flag <= 1'b0;
    else if (vs_fall) field_flag <= (phase > (period >> 1));
  end
endmodule

// File: rtl/cc_line_picker.sv
module cc_line_picker
  import cc_pick_pkg::*;
#(
  parameter int LINE_W    = 6,
  parameter int CFG_W     = 5,
  parameter int FIXED_CNT = 21,
  parameter int PH_W      = 12,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [CFG_W-1:0] cfg_line,
  input  logic [1:0]       cfg_ref_sel,
  input  logic             cfg_ref_field,
  output logic             slice_stb,
  output logic             ref_stb,
  output logic             field_flag
);
  localparam logic [LINE_W-1:0] FIX_CNT = LINE_W'(FIXED_CNT);

  logic hs_rise, hs_fall_unused, vs_rise_unused, vs_fall;
  logic [LINE_W-1:0] line_cnt, cnt_nxt;
  logic hit_prog, hit_fix, slice_d, ref_d;
  ref_sel_e sel;

  cc_sync_edge #(.STAGES(SYNC_STG)) u_hs (
    .clk(clk), .rst_n(rst_n), .async_in(hsync_in),
    .rise(hs_rise), .fall(hs_fall_unused));

  cc_sync_edge #(.STAGES(SYNC_STG)) u_vs (
    .clk(clk), .rst_n(rst_n), .async_in(vsync_in),
    .rise(vs_rise_unused), .fall(vs_fall));

  cc_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(vs_fall), .inc(hs_rise),
    .cnt(line_cnt), .cnt_nxt(cnt_nxt));

  cc_field_detect #(.PH_W(PH_W)) u_fld (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vs_fall(vs_fall),
    .field_flag(field_flag));

  // Compare the count this horizontal sync produces
  always_comb begin
    sel      = ref_sel_e'(cfg_ref_sel);
    hit_prog = hs_rise && !vs_fall && (cnt_nxt == LINE_W'(cfg_line));
    hit_fix  = hs_rise && !vs_fall && (cnt_nxt == FIX_CNT);
    slice_d  = hit_prog || hit_fix;
    unique case (sel)
      REF_FIXED: ref_d = hit_fix;
      REF_PROG:  ref_d = hit_prog;
      default:   ref_d = 1'b0;
    endcase
    ref_d = ref_d && (field_flag == cfg_ref_field);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_stb <= 1'b0;
      ref_stb   <= 1'b0;
    end else begin
      slice_stb <= slice_d;
      ref_stb   <= ref_d;
    end
  end
endmodule

// File: rtl/cc_line_picker_chk.sv
module cc_line_picker_chk #(
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slice_stb,
  input logic              ref_stb,
  input logic              field_flag,
  input logic              cfg_ref_field,
  input logic              vs_fall,
  input logic [LINE_W-1:0] line_cnt
);
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  // R1
  field_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_fall |=> line_cnt == '0);

  // R2
  slice_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_stb |=> !slice_stb);

  // R5
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt == CNT_MAX && !vs_fall) |=> line_cnt == CNT_MAX);

  // R6
  ref_on_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |-> slice_stb);

  // R7
  ref_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |-> $past(field_flag == cfg_ref_field));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_fall |=> $stable(field_flag));
endmodule

bind cc_line_picker cc_line_picker_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slice_stb(slice_stb), .ref_stb(ref_stb),
  .field_flag(field_flag), .cfg_ref_field(cfg_ref_field),
  .vs_fall(vs_fall), .line_cnt(line_cnt));

// File: tb/cc_line_picker_tb.sv
module cc_line_picker_tb;
  localparam int LINE_CYC = 20;
  localparam int FIX      = 21;
  localparam int CMAX     = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0;
  logic [4:0] cfg_line = 5'd0;
  logic [1:0] cfg_ref_sel = 2'b00;
  logic cfg_ref_field = 1'b0;
  logic slice_stb, ref_stb, field_flag;

  int checks = 0, failures = 0;
  int tb_line = 0;
  bit tb_field = 1'b0;
  bit done = 1'b0;

  typedef struct { int line; bit refx; } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  cc_line_picker u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .cfg_line(cfg_line), .cfg_ref_sel(cfg_ref_sel),
    .cfg_ref_field(cfg_ref_field), .slice_stb(slice_stb),
    .ref_stb(ref_stb), .field_flag(field_flag));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: model the line count and push the expected strobes
  task automatic predict();
    bit s, r;
    tb_line = (tb_line == CMAX) ? CMAX : tb_line + 1;
    s = (tb_line == FIX) || (tb_line == int'(cfg_line));
    case (cfg_ref_sel)
      2'b00:   r = (tb_line == FIX);
      2'b01:   r = (tb_line == int'(cfg_line));
      default: r = 1'b0;
    endcase
    r = r && (tb_field == cfg_ref_field);
    if (s) expq.push_back('{line: tb_line, refx: r});
  endtask

  task automatic hs_line();
    @(negedge clk);
    predict();
    hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    hsync_in = 1'b0;
    repeat (LINE_CYC - 3) @(negedge clk);
  endtask

  // Vertical sync falls early (first field) or late (second field) in a line
  task automatic vs_line(bit second);
    int dly;
    dly = second ? 9 : 1;
    vsync_in = 1'b1;
    @(negedge clk);
    predict();
    hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    hsync_in = 1'b0;
    repeat (dly) @(negedge clk);
    vsync_in = 1'b0;
    tb_line = 0;
    tb_field = second;
    repeat (LINE_CYC - 3 - dly) @(negedge clk);
    // R8: field flag loaded by the vertical sync falling edge
    chk("R8 field_flag", int'(field_flag), int'(second));
  endtask

  task automatic run_lines(int n);
    for (int i = 0; i < n; i++) hs_line();
  endtask

  // Monitor: pop and compare on every strobe
  always @(negedge clk) begin
    if (rst_n && !done && (slice_stb || ref_stb)) begin
      if (!slice_stb) begin
        chk("R6 ref_stb without slice_stb", 1, 0);
      end else if (expq.size() == 0) begin
        chk("R3/R4/R5 unexpected slice line", tb_line, -1);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk("R3/R4 slice line", tb_line, e.line);
        chk("R6/R7 ref_stb", int'(ref_stb), int'(e.refx));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 slice_stb", int'(slice_stb), 0);
    chk("R9 ref_stb", int'(ref_stb), 0);
    chk("R9 field_flag", int'(field_flag), 0);
    rst_n = 1'b1;
    run_lines(3);

    // R3/R4/R6: first field, fixed line drives reference
    cfg_line = 5'd5; cfg_ref_sel = 2'b00; cfg_ref_field = 1'b0;
    vs_line(1'b0);
    run_lines(25);

    // R2: latency of the strobe from the hsync rise
    cfg_line = 5'd2;
    vs_line(1'b0);
    @(negedge clk); tb_line = 1; hsync_in = 1'b1;
    repeat (2) @(negedge clk); hsync_in = 1'b0;
    repeat (LINE_CYC - 3) @(negedge clk);
    @(negedge clk);
    tb_line = 2;
    expq.push_back('{line: 2, refx: 1'b0});
    hsync_in = 1'b1;
    @(negedge clk); chk("R2 slice_stb edge k", int'(slice_stb), 0);
    @(negedge clk); chk("R2 slice_stb edge k+1", int'(slice_stb), 0);
    hsync_in = 1'b0;
    @(negedge clk);
    repeat (LINE_CYC - 4) @(negedge clk);
    run_lines(25);

    // R7/R6: second field, programmable line drives reference
    cfg_line = 5'd5; cfg_ref_sel = 2'b01; cfg_ref_field = 1'b1;
    vs_line(1'b1);
    run_lines(25);

    // R7: reference field mismatch gives no ref strobe
    cfg_ref_sel = 2'b00; cfg_ref_field = 1'b0;
    vs_line(1'b1);
    run_lines(25);

    // R4: programmable equal to fixed gives one strobe; R6 reserved code
    cfg_line = 5'd21; cfg_ref_sel = 2'b10; cfg_ref_field = 1'b0;
    vs_line(1'b0);
    run_lines(25);

    // R3: setting 0 never slices; R6 reserved code 11
    cfg_line = 5'd0; cfg_ref_sel = 2'b11;
    vs_line(1'b0);
    run_lines(25);

    // R5: long field, counter saturates, no extra strobes past 63
    cfg_line = 5'd22; cfg_ref_sel = 2'b01; cfg_ref_field = 1'b0;
    vs_line(1'b0);
    run_lines(100);

    // R1: a new field restarts the count
    cfg_line = 5'd3; cfg_ref_sel = 2'b01;
    vs_line(1'b0);
    run_lines(5);

    repeat (10) @(negedge clk);
    chk("R3/R4 all expected strobes seen", expq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule